// File: doc/BRIEF.md
# SPI Flash Status-Register Guard

This block is the command front-end of a serial NOR flash slave. It handles only the status register and the write-enable latch. It receives SPI mode-0 traffic (SCLK idle low, data captured on rising edges, driven on falling edges). It decodes the first byte of every chip-select window as an opcode. The supported opcodes are set-write-enable, read-status and write-status. Array access is not part of the block.

A write to the status register has two guards. The write-enable latch must be set, and the device must not be in hardware-protected mode. Hardware-protected mode means the synchronised write-protect pin is low while the status-write-disable bit is set. A write-status command that fails either guard is rejected, and so is any unknown opcode. After a rejection the block goes quiet: it ignores every further bit and holds the output driver off until chip select falls again.

All SPI pins and the write-protect pin are sampled by the block's own clock. SCLK must stay high and low for at least eight clock periods each. `spi_miso_oe` is the pad output-enable: the pad is high-Z whenever it is low.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset the status-write-disable bit, the quad-enable flag and the write-enable latch are all 0, `spi_miso_oe` is low, and the write-protect level is taken as high until the pin is sampled.
- R2: Opcode bits arrive MSB first on rising SCLK edges. Opcode 0x06 sets the write-enable latch once its eighth bit is captured.
- R3: Opcode 0x05 returns a status byte. Bit 7 is the write-disable bit, bit 6 is quad-enable, bit 1 is the write-enable latch, and the other bits are 0. The byte goes out MSB first, with each bit changing on a falling SCLK edge. `spi_miso_oe` is high from the first falling edge after the opcode until chip select rises. The byte repeats for as long as chip select stays low.
- R4: Opcode 0x01, when accepted, takes effect at the chip-select rising edge after one or more whole data bytes. Bit 7 of the first data byte becomes the write-disable bit and bit 6 becomes quad-enable. Later data bytes are ignored.
- R5: A committed write-status clears the write-enable latch.
- R6: With the synchronised write-protect level low and the write-disable bit 1 when the opcode completes, opcode 0x01 is rejected and the status register is unchanged.
- R7: Opcode 0x01 issued while the write-enable latch is 0 is rejected.
- R8: After a rejected write-status or an unknown opcode, the block ignores all bytes up to the next chip-select falling edge (a following 0x06 does not set the latch). `spi_miso_oe` stays low during that time.
- R9: If chip select rises with a data byte incomplete, or before any data byte, a write-status makes no change and the write-enable latch stays set.
- R10: With write-protect high, a write-status is accepted even when the write-disable bit is 1, and it can clear that bit.
- R11: Bytes after opcode 0x06 within the same chip-select window are ignored and leave `spi_miso_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data out, valid while the output enable is high |
| spi_miso_oe | output | 1 | Output-driver enable for the data-out pad |

## Verification
The hardest state to reach from the pins is hardware-protected mode with the write-enable latch still set. Getting there takes three transactions: a write-status with bit 7 set while write-protect is high, a fresh set-write-enable, and then write-protect pulled low with enough settling time for the synchroniser. The write-status that follows must be refused, and a read must then show the latch still set. The bench also aborts a write-status three bits into a byte. It sends an unknown opcode followed by 0x06 to show that standby swallows it.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_SET_WEL  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_RD_STAT  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WR_STAT  = 8'h01;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_RD_STAT,
    ST_WR_DATA,
    ST_QUIET,
    ST_STANDBY
  } cmd_state_e;

  function automatic logic [BYTE_W-1:0] pack_status(input logic srwd,
                                                    input logic qe,
                                                    input logic wel);
    logic [BYTE_W-1:0] s;
    s    = '0;
    s[7] = srwd;
    s[6] = qe;
    s[1] = wel;
    return s;
  endfunction

  function automatic logic hw_locked(input logic wp_level, input logic srwd);
    return (!wp_level) && srwd;
  endfunction

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sr_bitin.sv
module spi_sr_bitin #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            cs_n_s,
  input  logic            si_s,
  output logic            cs_fall,
  output logic            cs_rise,
  output logic            sclk_fall,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            mid_byte
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic          sclk_d, cs_d;
  logic          sclk_rise;
  logic [CW-1:0] bit_cnt;
  logic [BITS-1:0] sh;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        sh      <= {sh[BITS-2:0], si_s};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        done_q  <= (bit_cnt == LAST);
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = sh;
  assign mid_byte  = (bit_cnt != '0);
endmodule

// File: rtl/spi_sr_txout.sv
module spi_sr_txout #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_fall,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            enable,
  input  logic [BITS-1:0] load_val,
  output logic            so,
  output logic            oe
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0]   cnt;
  logic [BITS-1:0] sh;
  logic            oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (cs_fall || cs_rise) begin
      cnt  <= '0;
      oe_q <= 1'b0;
    end else if (sclk_fall && enable) begin
      sh   <= (cnt == '0) ? load_val : {sh[BITS-2:0], 1'b0};
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      oe_q <= 1'b1;
    end
  end

  assign so = sh[BITS-1];
  assign oe = oe_q;
endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int WP_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, si_s, wp_s;

  spi_sr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(pins_s)
  );
  assign {sclk_s, cs_n_s, si_s} = pins_s;

  spi_sr_sync #(.W(1), .STAGES(WP_SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
    .clk(clk), .rst_n(rst_n), .d(wp_n), .q(wp_s)
  );

  logic              cs_fall, cs_rise, sclk_fall, byte_done, mid_byte;
  logic [BYTE_W-1:0] rx_byte;

  spi_sr_bitin #(.BITS(BYTE_W)) u_bitin (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .si_s(si_s),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .rx_byte(rx_byte), .mid_byte(mid_byte)
  );

  cmd_state_e state;
  logic       wel_q, srwd_q, qe_q;
  logic [1:0] pend_q;
  logic       got_q;

  // named events, also observed by the checker
  logic op_done, wren_hit, rdsr_hit, wrsr_accept, wrsr_reject, op_unknown;
  logic data_done, wrsr_commit, tx_enable;

  assign op_done     = byte_done && (state == ST_OPCODE);
  assign wren_hit    = op_done && (rx_byte == OP_SET_WEL);
  assign rdsr_hit    = op_done && (rx_byte == OP_RD_STAT);
  assign wrsr_accept = op_done && (rx_byte == OP_WR_STAT) && wel_q &&
                       !hw_locked(wp_s, srwd_q);
  assign wrsr_reject = op_done && (rx_byte == OP_WR_STAT) && !wrsr_accept;
  assign op_unknown  = op_done && !wren_hit && !rdsr_hit &&
                       (rx_byte != OP_WR_STAT);
  assign data_done   = byte_done && (state == ST_WR_DATA);
  assign wrsr_commit = cs_rise && (state == ST_WR_DATA) && got_q && !mid_byte;
  assign tx_enable   = (state == ST_RD_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPCODE;
    end else if (cs_fall || cs_rise) begin
      state <= ST_OPCODE;
    end else if (op_done) begin
      if (wren_hit)         state <= ST_QUIET;
      else if (rdsr_hit)    state <= ST_RD_STAT;
      else if (wrsr_accept) state <= ST_WR_DATA;
      else                  state <= ST_STANDBY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      got_q  <= 1'b0;
    end else if (cs_fall) begin
      got_q  <= 1'b0;
    end else if (data_done && !got_q) begin
      pend_q <= rx_byte[7:6];
      got_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      srwd_q <= 1'b0;
      qe_q   <= 1'b0;
    end else begin
      if (wren_hit)         wel_q <= 1'b1;
      else if (wrsr_commit) wel_q <= 1'b0;
      if (wrsr_commit) begin
        srwd_q <= pend_q[1];
        qe_q   <= pend_q[0];
      end
    end
  end

  logic so_raw, oe_raw;

  spi_sr_txout #(.BITS(BYTE_W)) u_txout (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .enable(tx_enable),
    .load_val(pack_status(srwd_q, qe_q, wel_q)), .so(so_raw), .oe(oe_raw)
  );

  assign spi_miso_oe = oe_raw;
  assign spi_miso    = oe_raw ? so_raw : 1'b0;
endmodule

// File: rtl/spi_sr_guard_chk.sv
module spi_sr_guard_chk
  import spi_sr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input cmd_state_e state,
  input logic       oe,
  input logic       wel,
  input logic       srwd,
  input logic       qe,
  input logic       wren_hit,
  input logic       wrsr_reject,
  input logic       op_unknown,
  input logic       wrsr_commit,
  input logic       cs_rise
);
  a_r2_wren_sets_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wren_hit |=> wel);

  a_r5_commit_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |=> !wel);

  a_r4_status_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsr_commit |=> ($stable(srwd) && $stable(qe)));

  a_r7_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |-> wel);

  a_r8_reject_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_reject || op_unknown) |=> (state == ST_STANDBY));

  a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STANDBY) |-> !oe);

  a_r3_oe_off_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !oe);
endmodule

bind spi_sr_guard spi_sr_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .oe(spi_miso_oe), .wel(wel_q),
  .srwd(srwd_q), .qe(qe_q), .wren_hit(wren_hit), .wrsr_reject(wrsr_reject),
  .op_unknown(op_unknown), .wrsr_commit(wrsr_commit), .cs_rise(cs_rise)
);

// File: tb/spi_sr_guard_tb.sv
module spi_sr_guard_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp = 1'b1;
  logic miso, miso_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  bit m_srwd = 0, m_qe = 0, m_wel = 0;

  always #5 clk = ~clk;

  spi_sr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .wp_n(wp), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = 8'h00;
    s[7] = m_srwd;
    s[6] = m_qe;
    s[1] = m_wel;
    return s;
  endfunction

  // mode: 0 quiet, 1 read, 2 write data, 3 standby
  task automatic txn(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input int tail, input string tag);
    logic [7:0] bytes [3];
    int mode;
    logic [7:0] first_data;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    mode = 0;
    first_data = 8'h00;
    cs_n = 1'b0;
    tick(H);
    for (int k = 0; k <= n; k++) begin
      int nb;
      logic [7:0] st;
      nb = (k < n) ? 8 : tail;
      st = m_status();
      for (int i = 0; i < nb; i++) begin
        logic [7:0] tx;
        tx = (k < n) ? bytes[k] : 8'hFF;
        mosi = tx[7-i];
        tick(H);
        if (mode == 1 && k > 0) begin
          check(miso_oe === 1'b1, {tag, " oe"}, int'(miso_oe), 1);
          check(miso === st[7-i], {tag, " data"}, int'(miso), int'(st[7-i]));
        end else begin
          check(miso_oe === 1'b0, {tag, " oe off"}, int'(miso_oe), 0);
        end
        sclk = 1'b1;
        tick(H);
        sclk = 1'b0;
      end
      if (k == 0 && k < n) begin
        case (b0)
          8'h06: begin m_wel = 1; mode = 0; end
          8'h05: mode = 1;
          8'h01: mode = (m_wel && !(!wp && m_srwd)) ? 2 : 3;
          default: mode = 3;
        endcase
      end
      if (k == 1 && k < n) first_data = b1;
    end
    tick(H);
    cs_n = 1'b1;
    if (mode == 2 && n >= 2 && tail == 0) begin
      m_srwd = first_data[7];
      m_qe   = first_data[6];
      m_wel  = 0;
    end
    tick(3*H);
    check(miso_oe === 1'b0, {tag, " oe idle"}, int'(miso_oe), 0);
  endtask

  task automatic read_status(input string tag);
    txn(3, 8'h05, 8'h00, 8'h00, 0, tag);
  endtask

  task automatic set_wp(input logic v);
    wp = v;
    tick(10);
  endtask

  initial begin
    tick(4);
    check(miso_oe === 1'b0, "R1 reset oe", int'(miso_oe), 0);
    rst_n = 1'b1;
    tick(4);
    check(miso_oe === 1'b0, "R1 after reset oe", int'(miso_oe), 0);
    read_status("R1 reset status");
    read_status("R3 repeated status");

    txn(1, 8'h06, 8'h00, 8'h00, 0, "R2 set wel");
    read_status("R2 status after set");

    txn(2, 8'h01, 8'h80, 8'h00, 0, "R4 write status");
    read_status("R5 status after write");

    txn(2, 8'h01, 8'h00, 8'h00, 0, "R7 write without wel");
    read_status("R7 status unchanged");
    txn(2, 8'h01, 8'h06, 8'h00, 0, "R8 rejected then 06");
    read_status("R8 status after standby");

    txn(1, 8'h06, 8'h00, 8'h00, 0, "R6 set wel");
    set_wp(1'b0);
    txn(2, 8'h01, 8'h00, 8'h00, 0, "R6 locked write");
    read_status("R6 status kept, wel kept");

    set_wp(1'b1);
    txn(2, 8'h01, 8'h40, 8'h00, 0, "R10 unprotected write");
    read_status("R10 srwd cleared");

    txn(2, 8'h9F, 8'h06, 8'h00, 0, "R8 unknown opcode");
    read_status("R8 no wel after unknown");

    txn(1, 8'h06, 8'h00, 8'h00, 0, "R9 set wel");
    txn(2, 8'h01, 8'hC0, 8'h00, 3, "R9 partial byte");
    read_status("R9 status after abort");
    txn(1, 8'h01, 8'h00, 8'h00, 0, "R9 no data byte");
    read_status("R9 status after empty write");

    txn(3, 8'h01, 8'h80, 8'h00, 0, "R4 two data bytes");
    read_status("R4 first byte used");

    txn(3, 8'h06, 8'h05, 8'h00, 0, "R11 bytes after 06");
    read_status("R11 status wel set");
    txn(2, 8'h05, 8'h00, 8'h00, 5, "R3 partial read byte");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule